// File: doc/BRIEF.md
# Inter-Processor and Timer Interrupt Control

This block holds one 64-bit control word that drives two interrupt lines per processor, for up to four processors. A global timer tick marks every processor as having a pending tick, and raises that processor's tick interrupt line. Software acknowledges the tick by writing ones to the matching status bits. Any processor can signal another processor by writing a request bit. The target then gets an inter-processor interrupt line, which it acknowledges by writing the matching status bit.

Requests are counted per target. If a processor is signalled several times before it acknowledges, its interrupt line stays high until it has acknowledged as many times as it was signalled. A single write may acknowledge ticks, send requests and acknowledge requests all at once.

A write that names no known field is rejected. The block reports a rejected write with a one-cycle error pulse and leaves its state unchanged. Every write and every tick takes effect at the clock edge where it is presented. Reads are combinational.

Top module: `ipi_tick_ctrl`

## Requirements
- R1: After reset, `rd_data` is all zeros, `irq_tmr` and `irq_ipi` are zero, and `wr_err` is low.
- R2: When `tick` is high at a clock edge, the next cycle shows, for every processor i below N_CPU, tick status bit 4+i set and `irq_tmr[i]` high.
- R3: A write with bit 4+i set clears tick status bit 4+i and `irq_tmr[i]`. Zero bits in that field have no effect. If `tick` is high in the same cycle, the tick wins and the bit stays set.
- R4: A write with bit 12+i set does three things: it sets IPI status bit 8+i, it adds one to processor i's pending count, and it raises `irq_ipi[i]` when that count leaves zero.
- R5: A write with bit 8+i set clears IPI status bit 8+i and subtracts one from a nonzero pending count. `irq_ipi[i]` falls only when the count reaches zero. Acknowledging a count that is already zero changes nothing.
- R6: The pending count is 4 bits wide and saturates at 15. After 16 or more requests, 14 acknowledges leave `irq_ipi[i]` high and the 15th drops it.
- R7: The fields of one write are applied in this order: tick clear, then IPI request, then IPI clear. A write with both bits 12+i and 8+i set therefore leaves IPI status bit 8+i clear and the count unchanged, except that a saturated count of 15 becomes 14.
- R8: A write whose only set bit in the field area is bit 28 (error acknowledge) is accepted. It gives no `wr_err` pulse and changes no state.
- R9: A write with none of bits 4–15 or 28 set is unsupported. It produces `wr_err` high for exactly the following cycle and changes no state.
- R10: `rd_data` bits 4–7 show tick status and bits 8–11 show IPI status. All other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 64 | Write data |
| tick | input | 1 | Global timer tick, one cycle per tick |
| rd_data | output | 64 | Current control word |
| irq_tmr | output | N_CPU | Per-processor tick interrupt level |
| irq_ipi | output | N_CPU | Per-processor inter-processor interrupt level |
| wr_err | output | 1 | One-cycle pulse after an unsupported write |

## Verification
On every cycle, the assertions check the following edge relations:
- a tick interrupt rises only after a tick;
- a tick interrupt falls only after a clear that no tick overrode;
- an inter-processor line rises only after a request and falls only after a clear with no request in the same write;
- an error pulse follows only an unsupported write, and such a write leaves the interrupt lines stable;
- unused read bits are always zero.

The assertions cannot show the depth of the pending count. Its saturation at 15, the exact number of acknowledges that releases a line, and the ordering of fields in a combined write come only from the bench's directed sequences and its seeded random writes, compared against a reference model of the counts.

// File: rtl/ipc_pkg.sv
// Package: shared field positions and widths for the interrupt control word.
// Assumes a 64-bit word with 4-bit per-processor fields.
package ipc_pkg;
    localparam int DATA_W     = 64;
    localparam int MAX_CPU    = 4;
    localparam int TCLR_LSB   = 4;   // tick status / tick clear field
    localparam int ICLR_LSB   = 8;   // IPI status / IPI clear field
    localparam int IREQ_LSB   = 12;  // IPI request field
    localparam int ERRACK_BIT = 28;  // error acknowledge, accepted only
    localparam int CNT_W      = 4;   // pending count width
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
endpackage

// File: rtl/ipc_wr_decode.sv
// Module: splits a write into per-processor strobes and classifies it.
// Assumes N_CPU <= MAX_CPU; the strobes are qualified by wr_en.
module ipc_wr_decode
    import ipc_pkg::*;
#(
    parameter int N_CPU = 4
) (
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [N_CPU-1:0]  tclr,
    output logic [N_CPU-1:0]  ireq,
    output logic [N_CPU-1:0]  iclr,
    output logic              accept,
    output logic              reject
);
    logic known;
    logic unused_bits;

    // Classify: any field bit or the acknowledge bit makes the write supported.
    assign known  = (|wr_data[IREQ_LSB+MAX_CPU-1:TCLR_LSB]) | wr_data[ERRACK_BIT];
    assign accept = wr_en & known;
    assign reject = wr_en & ~known;

    // Per-processor strobes, generated from the field offsets.
    for (genvar i = 0; i < N_CPU; i++) begin : g_strb
        assign tclr[i] = accept & wr_data[TCLR_LSB+i];
        assign ireq[i] = accept & wr_data[IREQ_LSB+i];
        assign iclr[i] = accept & wr_data[ICLR_LSB+i];
    end

    assign unused_bits = ^{wr_data[DATA_W-1:ERRACK_BIT+1],
                           wr_data[ERRACK_BIT-1:IREQ_LSB+MAX_CPU],
                           wr_data[TCLR_LSB-1:0]};
endmodule

// File: rtl/ipc_tmr_slice.sv
// Module: tick status for one processor; the status bit is the interrupt level.
// Assumes tick and clear may coincide; the tick is applied last.
module ipc_tmr_slice (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic tclr,
    output logic st
);
    // Status register: clear first, then set by tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    st <= 1'b0;
        else if (tick) st <= 1'b1;
        else if (tclr) st <= 1'b0;
    end
endmodule

// File: rtl/ipc_ipi_slice.sv
// Module: inter-processor status bit and saturating pending count for one
// processor. Request is applied before clear within a single write.
module ipc_ipi_slice
    import ipc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ireq,
    input  logic iclr,
    output logic st,
    output logic busy
);
    logic [CNT_W-1:0] cnt, cnt_mid, cnt_nxt;

    // Next count: saturating increment, then decrement if nonzero.
    always_comb begin
        cnt_mid = cnt;
        if (ireq && cnt != CNT_MAX) cnt_mid = cnt + 1'b1;
        cnt_nxt = cnt_mid;
        if (iclr && cnt_mid != '0) cnt_nxt = cnt_mid - 1'b1;
    end

    // State update: count and status bit (clear overrides request).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            st  <= 1'b0;
        end else begin
            cnt <= cnt_nxt;
            if (iclr)      st <= 1'b0;
            else if (ireq) st <= 1'b1;
        end
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/ipi_tick_ctrl.sv
// Module: top of the interrupt control word. Instantiates the decoder and one
// tick slice and one IPI slice per processor; assembles the read word.
// Assumes synchronous active-low reset and single-cycle tick pulses.
module ipi_tick_ctrl
    import ipc_pkg::*;
#(
    parameter int N_CPU = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tick,
    output logic [DATA_W-1:0] rd_data,
    output logic [N_CPU-1:0]  irq_tmr,
    output logic [N_CPU-1:0]  irq_ipi,
    output logic              wr_err
);
    logic [N_CPU-1:0] tclr, ireq, iclr, tmr_st, ipi_st;
    logic             accept, reject;

    ipc_wr_decode #(.N_CPU(N_CPU)) u_dec (
        .wr_en(wr_en), .wr_data(wr_data),
        .tclr(tclr), .ireq(ireq), .iclr(iclr),
        .accept(accept), .reject(reject)
    );

    for (genvar i = 0; i < N_CPU; i++) begin : g_cpu
        ipc_tmr_slice u_tmr (
            .clk(clk), .rst_n(rst_n), .tick(tick),
            .tclr(tclr[i]), .st(tmr_st[i])
        );
        ipc_ipi_slice u_ipi (
            .clk(clk), .rst_n(rst_n), .ireq(ireq[i]),
            .iclr(iclr[i]), .st(ipi_st[i]), .busy(irq_ipi[i])
        );
    end

    assign irq_tmr = tmr_st;

    // Error pulse: one cycle after a rejected write.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_err <= 1'b0;
        else        wr_err <= reject;
    end

    // Read word: status fields placed, everything else zero.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < N_CPU; i++) begin
            rd_data[TCLR_LSB+i] = tmr_st[i];
            rd_data[ICLR_LSB+i] = ipi_st[i];
        end
    end

    logic unused_accept;
    assign unused_accept = accept;
endmodule

// File: rtl/ipc_chk.sv
// Checker: edge relations of the interrupt control word, bound to the top.
module ipc_chk
    import ipc_pkg::*;
#(
    parameter int N_CPU = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              tick,
    input logic [DATA_W-1:0] rd_data,
    input logic [N_CPU-1:0]  irq_tmr,
    input logic [N_CPU-1:0]  irq_ipi,
    input logic              wr_err
);
    logic bad_wr;
    assign bad_wr = wr_en && !(|wr_data[IREQ_LSB+MAX_CPU-1:TCLR_LSB]) && !wr_data[ERRACK_BIT];

    // Past-valid flag so that no $past looks before reset.
    logic seen;
    always_ff @(posedge clk) seen <= rst_n;

    for (genvar i = 0; i < N_CPU; i++) begin : g_a
        p_tmr_rise_r2: assert property (@(posedge clk) disable iff (!rst_n || !seen)
            $rose(irq_tmr[i]) |-> $past(tick));
        p_tmr_fall_r3: assert property (@(posedge clk) disable iff (!rst_n || !seen)
            $fell(irq_tmr[i]) |-> $past(wr_en && wr_data[TCLR_LSB+i] && !tick));
        p_ipi_rise_r4: assert property (@(posedge clk) disable iff (!rst_n || !seen)
            $rose(irq_ipi[i]) |-> $past(wr_en && wr_data[IREQ_LSB+i]));
        p_ipi_fall_r5: assert property (@(posedge clk) disable iff (!rst_n || !seen)
            $fell(irq_ipi[i]) |-> $past(wr_en && wr_data[ICLR_LSB+i] && !wr_data[IREQ_LSB+i]));
    end

    p_err_src_r9: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        wr_err |-> $past(bad_wr));
    p_bad_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bad_wr |=> ($stable(irq_ipi) && $stable(rd_data[ICLR_LSB+MAX_CPU-1:ICLR_LSB])));
    p_rsvd_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[DATA_W-1:ICLR_LSB+MAX_CPU] == '0) && (rd_data[TCLR_LSB-1:0] == '0));
endmodule

bind ipi_tick_ctrl ipc_chk #(.N_CPU(N_CPU)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .tick(tick), .rd_data(rd_data), .irq_tmr(irq_tmr),
    .irq_ipi(irq_ipi), .wr_err(wr_err)
);

// File: tb/ipi_tick_ctrl_bench.sv
`timescale 1ns/1ps
module ipi_tick_ctrl_bench;
    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic        tick = 1'b0;
    logic [63:0] rd_data;
    logic [N-1:0] irq_tmr, irq_ipi;
    logic        wr_err;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // Reference model state
    bit m_tmr [N];
    bit m_ist [N];
    int m_cnt [N];
    bit m_err;

    always #2.5 clk = ~clk;

    ipi_tick_ctrl #(.N_CPU(N)) u_ipi_tick_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .tick(tick), .rd_data(rd_data), .irq_tmr(irq_tmr),
        .irq_ipi(irq_ipi), .wr_err(wr_err)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_rd();
        logic [63:0] r = '0;
        for (int i = 0; i < N; i++) begin
            r[4+i] = m_tmr[i];
            r[8+i] = m_ist[i];
        end
        return r;
    endfunction

    // Model of one edge: clear ticks, request, clear IPIs, then tick (R3, R7).
    function automatic void model(input bit we, input logic [63:0] d, input bit tk);
        bit known = (|d[15:4]) | d[28];
        m_err = we && !known;
        if (we && known) begin
            for (int i = 0; i < N; i++) begin
                if (d[4+i]) m_tmr[i] = 0;
                if (d[12+i]) begin
                    m_ist[i] = 1;
                    if (m_cnt[i] < 15) m_cnt[i]++;
                end
                if (d[8+i]) begin
                    m_ist[i] = 0;
                    if (m_cnt[i] > 0) m_cnt[i]--;
                end
            end
        end
        if (tk) for (int i = 0; i < N; i++) m_tmr[i] = 1;
    endfunction

    task automatic step(input string req, input bit we, input logic [63:0] d, input bit tk);
        logic [N-1:0] e2, e3;
        @(negedge clk);
        wr_en = we; wr_data = d; tick = tk;
        @(posedge clk);
        model(we, d, tk);
        #1;
        wr_en = 0; wr_data = '0; tick = 0;
        for (int i = 0; i < N; i++) begin
            e2[i] = m_tmr[i];
            e3[i] = (m_cnt[i] != 0);
        end
        chk({req, " rd_data R10"}, rd_data, exp_rd());
        chk({req, " irq_tmr"}, 64'(irq_tmr), 64'(e2));
        chk({req, " irq_ipi"}, 64'(irq_ipi), 64'(e3));
        chk({req, " wr_err"}, 64'(wr_err), 64'(m_err));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < N; i++) begin m_tmr[i] = 0; m_ist[i] = 0; m_cnt[i] = 0; end
        m_err = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        #0.5;
        // R1: reset state
        chk("R1 rd_data", rd_data, '0);
        chk("R1 irqs", 64'({irq_tmr, irq_ipi, wr_err}), '0);

        // R2: tick sets every processor
        step("R2 tick", 0, '0, 1);
        // R3: clear processor 1 only; zero bits leave others
        step("R3 clear one", 1, 64'h20, 0);
        // R3: clear with simultaneous tick, tick wins
        step("R3 tick wins", 1, 64'hF0, 1);
        step("R3 clear all", 1, 64'hF0, 0);
        // R4: request to processor 2
        step("R4 req", 1, 64'h4000, 0);
        step("R4 req again", 1, 64'h4000, 0);
        // R5: first clear keeps line, second drops it, third is a no-op
        step("R5 clear keep", 1, 64'h400, 0);
        step("R5 clear drop", 1, 64'h400, 0);
        step("R5 clear zero", 1, 64'h400, 0);
        // R6: saturation on processor 0
        for (int k = 0; k < 20; k++) step("R6 fill", 1, 64'h1000, 0);
        for (int k = 0; k < 14; k++) step("R6 drain keep", 1, 64'h100, 0);
        step("R6 drain last", 1, 64'h100, 0);
        // R7: combined request and clear, and at saturation
        step("R7 req", 1, 64'h2000, 0);
        step("R7 both", 1, 64'h2200, 0);
        for (int k = 0; k < 16; k++) step("R7 sat", 1, 64'h8000, 0);
        step("R7 both at sat", 1, 64'h8880, 1);
        // R8: error acknowledge only
        step("R8 ack", 1, 64'h1000_0000, 0);
        // R9: unsupported write, then pulse ends
        step("R9 bad", 1, 64'hFFFF_0000_0000_000F, 0);
        step("R9 after", 0, '0, 0);
        // Seeded random mix of fields, ticks and junk bits
        for (int k = 0; k < 400; k++) begin
            logic [63:0] d;
            bit we = ($urandom_range(0, 3) != 0);
            d = {$urandom, $urandom};
            case ($urandom_range(0, 5))
                0: d = d & 64'h0000_0000_0000_F000;
                1: d = d & 64'h0000_0000_0000_0F00;
                2: d = d & 64'h0000_0000_0000_FFF0;
                3: d = d & 64'h1000_0000_0000_0000 | (d & 64'h1000_0000);
                4: d = d & 64'hFFFF_FFFF_EFFF_000F;
                default: ;
            endcase
            step("R4 R5 R10 random", we, d, ($urandom_range(0, 7) == 0));
        end
        finish_run();
    end
endmodule